// File: doc/BRIEF.md
# Indexed-Enable Multi-CPU Interrupt Controller

This block collects level-sensitive interrupt lines and delivers them to up to four processors. Software never edits enable or mask bitmaps directly. To turn a source on or off it writes that source's number to a set register or a clear register. Each CPU masks or unmasks a source the same way, through its own window. Every source also has a routing word. The word chooses which CPUs receive the source as a normal interrupt and which receive it as a fast interrupt.

Each CPU reads its own acknowledge register to find out which source to service. The read returns the lowest-numbered source that is active, enabled, unmasked for that CPU and routed to it. A reserved identifier means nothing is pending. The acknowledge read has no side effects. Because sources are level-sensitive, a source stays pending for as long as its input is high and drops out as soon as the input falls.

Source 5 is the per-CPU timer. Its mask bit is held separately for each CPU. Every other source has one mask bit shared by all CPUs. The bus has two windows, selected by address bit 12: the global window (bit 12 = 0) and the per-CPU window (bit 12 = 1). In the per-CPU window the `bus_cpu` input names the CPU making the access.

Top module: `mpic_top`

## Requirements
- R1: After reset every source is disabled, every routing bit is zero and every mask bit is set, including the four timer masks. All `irq_o` and `fiq_o` outputs are low, every acknowledge read returns 1023 and every routing word reads 0.
- R2: A write of index n to global offset 0x030 sets the enable of source n. A write of n to global offset 0x034 clears it. Only write-data bits [9:0] form the index. An index of NSRC or more changes nothing.
- R3: A write of index n to per-CPU offset 0x048 sets the mask of source n, and a write to per-CPU offset 0x04C clears it. For every source other than the timer, this mask is shared by all CPUs, whichever CPU performs the write.
- R4: For the timer source (index 5), a mask set or clear write changes only the mask of the CPU given on `bus_cpu`. Mask writes naming any other source leave all timer masks unchanged.
- R5: The routing word of source n is at global offset 0x100 + 4n. Bits [NCPU-1:0] route the source as a normal interrupt to the CPU with that bit number. Bits [8+NCPU-1:8] route it as a fast interrupt. A read returns exactly these bits, with every other bit zero.
- R6: A read of per-CPU offset 0x044 returns in bits [9:0] the lowest-numbered qualifying source for that CPU, or 1023 if none qualifies. A source qualifies when its input is high, it is enabled, it is unmasked for that CPU and its normal-interrupt route bit for that CPU is set. The read does not change any state.
- R7: A read of per-CPU offset 0x010 returns a bitmap in which bit n is set exactly when source n qualifies for that CPU.
- R8: `irq_o[c]` is high exactly when at least one source qualifies for CPU c.
- R9: `fiq_o[c]` is high exactly when some source is active, enabled, unmasked for CPU c and has its fast-interrupt route bit for CPU c set.
- R10: A read of global offset 0x000 returns NSRC in bits [11:2], with all other bits zero.
- R11: A source stops being reported the moment its input falls, with no clearing write needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Level-sensitive interrupt source lines |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 13 | Byte address; bit 12 selects the per-CPU window |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | 2 | CPU making a per-CPU access |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_o | output | NCPU | Normal interrupt request per CPU |
| fiq_o | output | NCPU | Fast interrupt request per CPU |

## Verification
The assertions check these properties on every cycle: the reset values, enable set and clear behaviour, rejection of out-of-range indices, isolation of the timer masks from writes to other sources, and the match between each CPU's request line and its acknowledged identifier, including that the identifier is the lowest pending one. The bench's scenarios are needed for the rest. These are the routing-word layout as software reads it back, the sharing of a non-timer mask across CPUs, fast-interrupt delivery, and the interaction of many sources, routes and masks. The bench checks these against a register model of its own, sweeping every source alone and then dense mixed patterns.

// File: rtl/mpic_pkg.sv
// Shared constants for the indexed-enable interrupt controller.
package mpic_pkg;
    localparam int AW      = 13;   // bus address width; bit 12 picks the per-CPU window
    localparam int DW      = 32;   // bus data width
    localparam int IDW     = 10;   // width of a source identifier
    localparam int FIQ_LSB = 8;    // first fast-interrupt route bit in a routing word
    localparam logic [IDW-1:0] NO_SRC = 10'd1023;

    // global window
    localparam logic [11:0] G_CTRL     = 12'h000;
    localparam logic [11:0] G_EN_SET   = 12'h030;
    localparam logic [11:0] G_EN_CLR   = 12'h034;
    localparam logic [11:0] G_RT_BASE  = 12'h100;
    // per-CPU window
    localparam logic [11:0] C_CAUSE    = 12'h010;
    localparam logic [11:0] C_ACK      = 12'h044;
    localparam logic [11:0] C_MK_SET   = 12'h048;
    localparam logic [11:0] C_MK_CLR   = 12'h04C;
endpackage

// File: rtl/mpic_state.sv
// Holds enable, mask and routing state, updated by indexed writes.
// Assumes one decoded write strobe at most per cycle; an out-of-range
// index is dropped. The timer source keeps one mask bit per CPU.
module mpic_state
    import mpic_pkg::*;
#(
    parameter int NSRC      = 32,
    parameter int NCPU      = 4,
    parameter int TIMER_SRC = 5,
    localparam int SW = $clog2(NSRC),
    localparam int CW = $clog2(NCPU)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_set,
    input  logic                       en_clr,
    input  logic                       mk_set,
    input  logic                       mk_clr,
    input  logic                       rt_we,
    input  logic [IDW-1:0]             idx,
    input  logic [CW-1:0]              cpu,
    input  logic [NCPU-1:0]            rt_irq_d,
    input  logic [NCPU-1:0]            rt_fiq_d,
    output logic [NSRC-1:0]            en_q,
    output logic [NSRC-1:0]            smask_q,
    output logic [NCPU-1:0]            tmask_q,
    output logic [NSRC-1:0][NCPU-1:0]  rt_irq_q,
    output logic [NSRC-1:0][NCPU-1:0]  rt_fiq_q
);
    logic          idx_ok;
    logic [SW-1:0] sel;

    // index range check and bit select
    always_comb begin
        idx_ok = idx < IDW'(NSRC);
        sel    = idx[SW-1:0];
    end

    // state update on reset or on a decoded indexed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            smask_q  <= '1;
            tmask_q  <= '1;
            rt_irq_q <= '0;
            rt_fiq_q <= '0;
        end else if (idx_ok) begin
            if (en_set) en_q[sel] <= 1'b1;
            if (en_clr) en_q[sel] <= 1'b0;
            if (mk_set || mk_clr) begin
                if (int'(sel) == TIMER_SRC) tmask_q[cpu]  <= mk_set;
                else                        smask_q[sel]  <= mk_set;
            end
            if (rt_we) begin
                rt_irq_q[sel] <= rt_irq_d;
                rt_fiq_q[sel] <= rt_fiq_d;
            end
        end
    end
endmodule

// File: rtl/mpic_qualify.sv
// Forms the per-CPU pending matrices for normal and fast interrupts.
// Purely combinational; the timer source uses the per-CPU mask.
module mpic_qualify #(
    parameter int NSRC      = 32,
    parameter int NCPU      = 4,
    parameter int TIMER_SRC = 5
) (
    input  logic [NSRC-1:0]            src_i,
    input  logic [NSRC-1:0]            en_q,
    input  logic [NSRC-1:0]            smask_q,
    input  logic [NCPU-1:0]            tmask_q,
    input  logic [NSRC-1:0][NCPU-1:0]  rt_irq_q,
    input  logic [NSRC-1:0][NCPU-1:0]  rt_fiq_q,
    output logic [NCPU-1:0][NSRC-1:0]  pend_irq,
    output logic [NCPU-1:0][NSRC-1:0]  pend_fiq
);
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        for (genvar n = 0; n < NSRC; n++) begin : g_src
            logic live;
            // pick the mask that applies to this source on this CPU
            if (n == TIMER_SRC) begin : g_tmr
                assign live = src_i[n] & en_q[n] & ~tmask_q[c];
            end else begin : g_shr
                assign live = src_i[n] & en_q[n] & ~smask_q[n];
            end
            assign pend_irq[c][n] = live & rt_irq_q[n][c];
            assign pend_fiq[c][n] = live & rt_fiq_q[n][c];
        end
    end
endmodule

// File: rtl/mpic_pick.sv
// Fixed-order selector: returns the lowest set index, or the
// reserved none value when the vector is empty.
module mpic_pick
    import mpic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0] pend,
    output logic [IDW-1:0]  id,
    output logic            any
);
    // scan from the top so the lowest index wins
    always_comb begin
        id = NO_SRC;
        for (int n = NSRC - 1; n >= 0; n--) begin
            if (pend[n]) id = IDW'(n);
        end
        any = |pend;
    end
endmodule

// File: rtl/mpic_top.sv
// Indexed-enable interrupt controller for NCPU processors.
// Decodes the two bus windows, keeps state in mpic_state, qualifies
// sources per CPU and selects the acknowledge identifier per CPU.
// Assumes NSRC <= 32 so the cause bitmap fits one data word.
module mpic_top
    import mpic_pkg::*;
#(
    parameter int NSRC      = 32,
    parameter int NCPU      = 4,
    parameter int TIMER_SRC = 5,
    localparam int SW = $clog2(NSRC),
    localparam int CW = $clog2(NCPU)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [CW-1:0]    bus_cpu,
    output logic [DW-1:0]    bus_rdata,
    output logic [NCPU-1:0]  irq_o,
    output logic [NCPU-1:0]  fiq_o
);
    logic                       cpu_win;
    logic [11:0]                off;
    logic                       rt_hit;
    logic [IDW-1:0]             rt_idx;
    logic                       we_en_set, we_en_clr, we_mk_set, we_mk_clr, we_rt;
    logic [IDW-1:0]             idx;
    logic [NSRC-1:0]            en_q, smask_q;
    logic [NCPU-1:0]            tmask_q;
    logic [NSRC-1:0][NCPU-1:0]  rt_irq_q, rt_fiq_q;
    logic [NCPU-1:0][NSRC-1:0]  pend_irq, pend_fiq;
    logic [NCPU-1:0][IDW-1:0]   ack_id;

    // address decode into write strobes and the routing-word index
    always_comb begin
        cpu_win   = bus_addr[AW-1];
        off       = bus_addr[11:0];
        rt_hit    = !cpu_win && off >= G_RT_BASE &&
                    off < (G_RT_BASE + 12'(4 * NSRC)) && off[1:0] == 2'b00;
        rt_idx    = IDW'((off - G_RT_BASE) >> 2);
        we_en_set = bus_we && !cpu_win && off == G_EN_SET;
        we_en_clr = bus_we && !cpu_win && off == G_EN_CLR;
        we_mk_set = bus_we &&  cpu_win && off == C_MK_SET;
        we_mk_clr = bus_we &&  cpu_win && off == C_MK_CLR;
        we_rt     = bus_we && rt_hit;
        idx       = rt_hit ? rt_idx : bus_wdata[IDW-1:0];
    end

    mpic_state #(.NSRC(NSRC), .NCPU(NCPU), .TIMER_SRC(TIMER_SRC)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set   (we_en_set),
        .en_clr   (we_en_clr),
        .mk_set   (we_mk_set),
        .mk_clr   (we_mk_clr),
        .rt_we    (we_rt),
        .idx      (idx),
        .cpu      (bus_cpu),
        .rt_irq_d (bus_wdata[NCPU-1:0]),
        .rt_fiq_d (bus_wdata[FIQ_LSB +: NCPU]),
        .en_q     (en_q),
        .smask_q  (smask_q),
        .tmask_q  (tmask_q),
        .rt_irq_q (rt_irq_q),
        .rt_fiq_q (rt_fiq_q)
    );

    mpic_qualify #(.NSRC(NSRC), .NCPU(NCPU), .TIMER_SRC(TIMER_SRC)) u_qual (
        .src_i    (src_i),
        .en_q     (en_q),
        .smask_q  (smask_q),
        .tmask_q  (tmask_q),
        .rt_irq_q (rt_irq_q),
        .rt_fiq_q (rt_fiq_q),
        .pend_irq (pend_irq),
        .pend_fiq (pend_fiq)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_pick
        mpic_pick #(.NSRC(NSRC)) u_pick (
            .pend (pend_irq[c]),
            .id   (ack_id[c]),
            .any  (irq_o[c])
        );
        assign fiq_o[c] = |pend_fiq[c];
    end

    // read mux; reads have no side effects
    always_comb begin
        bus_rdata = '0;
        if (cpu_win) begin
            if (off == C_ACK)   bus_rdata[IDW-1:0]  = ack_id[bus_cpu];
            if (off == C_CAUSE) bus_rdata[NSRC-1:0] = pend_irq[bus_cpu];
        end else if (off == G_CTRL) begin
            bus_rdata[IDW+1:2] = IDW'(NSRC);
        end else if (rt_hit) begin
            bus_rdata[NCPU-1:0]         = rt_irq_q[rt_idx[SW-1:0]];
            bus_rdata[FIQ_LSB +: NCPU]  = rt_fiq_q[rt_idx[SW-1:0]];
        end
    end
endmodule

// File: rtl/mpic_chk.sv
// Assertion checker for mpic_top, attached with bind below.
// Observes decoded strobes, state registers and per-CPU results.
module mpic_chk
    import mpic_pkg::*;
#(
    parameter int NSRC      = 32,
    parameter int NCPU      = 4,
    parameter int TIMER_SRC = 5,
    localparam int SW = $clog2(NSRC)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       we_en_set,
    input logic                       we_en_clr,
    input logic                       we_mk_set,
    input logic                       we_mk_clr,
    input logic [IDW-1:0]             idx,
    input logic [NSRC-1:0]            en_q,
    input logic [NCPU-1:0]            tmask_q,
    input logic [NSRC-1:0]            smask_q,
    input logic [NSRC-1:0][NCPU-1:0]  rt_irq_q,
    input logic [NCPU-1:0][NSRC-1:0]  pend_irq,
    input logic [NCPU-1:0][IDW-1:0]   ack_id,
    input logic [NCPU-1:0]            irq_o
);
    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && smask_q == '1 && tmask_q == '1 && rt_irq_q == '0));

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_en_set && idx < IDW'(NSRC)) |=> en_q[$past(idx[SW-1:0])]);

    // R2
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_en_clr && idx < IDW'(NSRC)) |=> !en_q[$past(idx[SW-1:0])]);

    // R2
    en_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((we_en_set || we_en_clr) && idx >= IDW'(NSRC)) |=> $stable(en_q));

    // R4
    tmask_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((we_mk_set || we_mk_clr) && idx != IDW'(TIMER_SRC)) |=> $stable(tmask_q));

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NSRC-1:0] below;
        assign below = (NSRC'(1) << ack_id[c][SW-1:0]) - NSRC'(1);

        // R6
        none_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_o[c] |-> ack_id[c] == NO_SRC);

        // R6
        valid_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> (ack_id[c] < IDW'(NSRC) && pend_irq[c][ack_id[c][SW-1:0]]));

        // R6
        lowest_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> (pend_irq[c] & below) == '0);
    end
endmodule

bind mpic_top mpic_chk #(.NSRC(NSRC), .NCPU(NCPU), .TIMER_SRC(TIMER_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_en_set (we_en_set),
    .we_en_clr (we_en_clr),
    .we_mk_set (we_mk_set),
    .we_mk_clr (we_mk_clr),
    .idx       (idx),
    .en_q      (en_q),
    .tmask_q   (tmask_q),
    .smask_q   (smask_q),
    .rt_irq_q  (rt_irq_q),
    .pend_irq  (pend_irq),
    .ack_id    (ack_id),
    .irq_o     (irq_o)
);

// File: tb/mpic_top_tb.sv
module mpic_top_tb;
    localparam int NSRC = 32;
    localparam int NCPU = 4;
    localparam int TMR  = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  src_i = '0;
    logic             bus_we = 1'b0;
    logic [12:0]      bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [1:0]       bus_cpu = '0;
    logic [31:0]      bus_rdata;
    logic [NCPU-1:0]  irq_o, fiq_o;

    int total = 0;
    int fails = 0;

    // bench register model
    logic [NSRC-1:0] m_en  = '0;
    logic [NSRC-1:0] m_sm  = '1;
    logic [NCPU-1:0] m_tm  = '1;
    logic [NCPU-1:0] m_ri [NSRC];
    logic [NCPU-1:0] m_rf [NSRC];

    always #5 clk = ~clk;

    mpic_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d, input int c);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = 2'(c);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, input int c, output logic [31:0] d);
        bus_addr = a; bus_cpu = 2'(c);
        #1 d = bus_rdata;
    endtask

    function automatic logic [NSRC-1:0] live(input int c);
        logic [NSRC-1:0] v;
        for (int n = 0; n < NSRC; n++) begin
            logic msk;
            msk  = (n == TMR) ? m_tm[c] : m_sm[n];
            v[n] = src_i[n] & m_en[n] & ~msk;
        end
        return v;
    endfunction

    // compare every CPU's acknowledge, cause, irq and fiq with the model
    task automatic check_all(input string req);
        logic [31:0] d;
        for (int c = 0; c < NCPU; c++) begin
            logic [NSRC-1:0] lv, pi, pf;
            logic [31:0] exp_id;
            lv = live(c);
            for (int n = 0; n < NSRC; n++) begin
                pi[n] = lv[n] & m_ri[n][c];
                pf[n] = lv[n] & m_rf[n][c];
            end
            exp_id = 32'd1023;
            for (int n = NSRC - 1; n >= 0; n--) if (pi[n]) exp_id = n;
            @(negedge clk);
            rd(13'h1000 | 13'h044, c, d);
            chk(d == exp_id, req, "ack id", d, exp_id);
            rd(13'h1000 | 13'h010, c, d);
            chk(d == pi, "R7", "cause", d, pi);
            chk(irq_o[c] == |pi, "R8", "irq_o", 32'(irq_o[c]), 32'(|pi));
            chk(fiq_o[c] == |pf, "R9", "fiq_o", 32'(fiq_o[c]), 32'(|pf));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] lf;
        for (int n = 0; n < NSRC; n++) begin m_ri[n] = '0; m_rf[n] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        src_i = '1;

        // R1: reset state with every input high
        check_all("R1");
        for (int n = 0; n < NSRC; n += 7) begin
            rd(13'h100 + 13'(4 * n), 0, d);
            chk(d == 0, "R1", "route after reset", d, 0);
        end
        // R10: source count
        rd(13'h000, 0, d);
        chk(d == 32'(NSRC << 2), "R10", "control word", d, 32'(NSRC << 2));

        // R5: routing words with junk in unused bits
        for (int n = 0; n < NSRC; n++) begin
            logic [3:0] ri, rf;
            ri = 4'((n * 5 + 1) % 16);
            rf = 4'((n * 3) % 16);
            wr(13'h100 + 13'(4 * n), {16'hABCD, 4'hF, rf, 4'hE, ri}, 0);
            m_ri[n] = ri; m_rf[n] = rf;
            rd(13'h100 + 13'(4 * n), 0, d);
            chk(d == {20'h0, rf, 4'h0, ri}, "R5", "route readback", d, {20'h0, rf, 4'h0, ri});
        end

        // R2: enable every source; masks still set so nothing pending
        for (int n = 0; n < NSRC; n++) begin
            wr(13'h030, {22'h3FFFFF, 10'(n)}, 0);   // upper bits ignored
            m_en[n] = 1'b1;
        end
        check_all("R2");

        // R3: unmask from varying CPUs; timer unmasked for CPUs 1 and 3
        for (int n = 0; n < NSRC; n++) begin
            wr(13'h1000 | 13'h04C, 32'(n), n % NCPU);
            if (n == TMR) m_tm[n % NCPU] = 1'b0; else m_sm[n] = 1'b0;
        end
        wr(13'h1000 | 13'h04C, 32'(TMR), 3);
        m_tm[3] = 1'b0;
        check_all("R3");

        // R6: each source alone
        for (int n = 0; n < NSRC; n++) begin
            src_i = NSRC'(1) << n;
            check_all("R6");
        end

        // R6: dense mixed patterns
        lf = 32'hACE1_2345;
        for (int k = 0; k < 24; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            src_i = lf & {lf[15:0], lf[31:16]};
            check_all("R6");
        end

        // R4: timer mask set from CPU 3 only affects CPU 3
        wr(13'h1000 | 13'h048, 32'(TMR), 3);
        m_tm[3] = 1'b1;
        wr(13'h100 + 13'(4 * TMR), 32'h0F0F, 0);
        m_ri[TMR] = 4'hF; m_rf[TMR] = 4'hF;
        src_i = NSRC'(1) << TMR;
        check_all("R4");

        // R4: masking a shared source leaves timer masks alone
        wr(13'h1000 | 13'h048, 32'd7, 1);
        m_sm[7] = 1'b1;
        check_all("R4");

        // R3: the shared mask on source 7 hides it from every CPU
        wr(13'h100 + 13'(4 * 7), 32'h0F0F, 0);
        m_ri[7] = 4'hF; m_rf[7] = 4'hF;
        src_i = NSRC'(1) << 7;
        check_all("R3");

        // R2: clear enable, then out-of-range indices do nothing
        src_i = '1;
        wr(13'h034, 32'd0, 0);
        m_en[0] = 1'b0;
        check_all("R2");
        wr(13'h034, 32'd40, 0);
        wr(13'h034, 32'd1023, 0);
        wr(13'h030, 32'd32, 0);
        check_all("R2");

        // R11: inputs fall, everything clears without any write
        src_i = '0;
        check_all("R11");
        src_i = 32'h8000_0102;
        check_all("R11");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule